// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder Model

This block is a clocked, synthesizable stand-in for the device side of an extended-data-out DRAM. It lets a memory controller be checked inside a self-checking simulation. A fast system clock samples the four active-low strobes (row strobe, column strobe, write enable, output enable) together with the multiplexed address. From the order in which the strobe edges arrive, the block sorts every access into one of six classes: read, early write, delayed or read-modify-write, row-only refresh, column-before-row refresh, and self refresh. A small array holds the data. The word that was read stays on the data output after the column strobe rises, which is the extended-data-out behaviour.

The block also tracks power-up initialization and raises a sticky protocol-violation flag. The strobe pins are paced by the controller and there is no back-pressure: each strobe edge is acted on at the clock edge that samples it. Array depth, data width, the initialization count and the two hold-time windows are parameters, so a simulation can use a much smaller array than a real device.

Top module: `edram_model`

## Requirements
- R1: While reset is low and on the first cycle after it, `dq_oe`, `ready`, `violation` and `cyc_kind_vld` are all 0.
- R2: Read. The row address is latched when `ras_n` falls with `cas_n` high. The column address is latched when `cas_n` falls with `we_n` high. From the next clock, `dq_out` shows the stored word and `dq_oe` equals "read data held AND `oe_n` low". At the end of that column cycle (`cas_n` or `ras_n` rising), `cyc_kind` reports 1.
- R3: Early write. If `we_n` is already low when `cas_n` falls, `din` is written to the addressed word. `dq_oe` stays 0 for the whole column cycle, and `cyc_kind` reports 2.
- R4: Delayed or read-modify-write. If `we_n` falls while `cas_n` is low during a read cycle, `din` is written at that edge to the column latched at the `cas_n` fall. `dq_oe` goes to 0 and `cyc_kind` reports 3. If the output is still driven when `we_n` falls, `violation` is set.
- R5: Read data stays driven while `ras_n` is low after `cas_n` rises. It is released at the clock that first sees both `ras_n` and `cas_n` high.
- R6: A `ras_n` low pulse during which `cas_n` never falls reports `cyc_kind` 4 when `ras_n` rises. It counts as a refresh, leaves the array unchanged and never turns the output on.
- R7: If `cas_n` is low when `ras_n` falls, `cyc_kind` reports 5 at that edge. The address is ignored, the array is unchanged, and the cycle counts as a refresh.
- R8: If `ras_n` and `cas_n` are both held low for `SELF_REF_CYC` clocks after a column-before-row entry, `cyc_kind` reports 6. A shorter hold reports nothing beyond the 5.
- R9: `ready` rises after `INIT_CYC` refresh cycles (kind 4 or 5) and then stays high. A `cas_n` fall inside an access cycle before `ready` sets `violation`.
- R10: If `ras_n` is held low in an access cycle for `PAGE_MAX_CYC` clocks, `violation` is set.
- R11: A refresh entered with `cas_n` still low from the previous access cycle (a hidden refresh) keeps the read word driven. If that access cycle's last column cycle was not a plain read, `violation` is set.
- R12: `violation` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| din | input | DQ_W | Write data |
| dq_out | output | DQ_W | Read data |
| dq_oe | output | 1 | Read data is being driven |
| cyc_kind | output | 3 | Cycle class: 1 read, 2 early write, 3 delayed write, 4 row-only refresh, 5 column-before-row refresh, 6 self refresh |
| cyc_kind_vld | output | 1 | One-clock pulse qualifying `cyc_kind` |
| ready | output | 1 | Initialization refreshes complete |
| violation | output | 1 | Sticky protocol-violation flag |

## Verification
The bench targets the edge orderings that separate one class from another. A decoder that judged the write type by the level of `we_n` at the end of the cycle would report an early write as a delayed one, or write at the wrong column. A hidden refresh behind a read is exercised to catch an output that drops on the first `ras_n` rise, and page-mode reads catch an output cut at `cas_n` rise. The window counters are probed just short of and just past their limits, so a counter off by a large margin or never resetting shows up as a missing or spurious self-refresh report or violation. A row-only refresh and a column-before-row refresh with a live address are followed by readback, which exposes refresh logic that writes the array.

// File: rtl/edram_pkg.sv
package edram_pkg;
  typedef enum logic [2:0] {
    K_NONE    = 3'd0,
    K_READ    = 3'd1,
    K_EWR     = 3'd2,
    K_LWR     = 3'd3,
    K_RASONLY = 3'd4,
    K_CBR     = 3'd5,
    K_SELF    = 3'd6
  } dram_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACT  = 2'd1,
    PH_CBR  = 2'd2,
    PH_SELF = 2'd3
  } dram_phase_e;
endpackage

// File: rtl/edram_store.sv
module edram_store #(
  parameter int ROW_W = 6,
  parameter int COL_W = 4,
  parameter int DQ_W  = 4,
  localparam int IDX_W = ROW_W + COL_W,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [DQ_W-1:0]  wdata,
  output logic [DQ_W-1:0]  rdata
);
  logic [DQ_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];
endmodule

// File: rtl/edram_init.sv
module edram_init #(
  parameter int INIT_CYC = 8,
  localparam int IC_W = $clog2(INIT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_evt,
  output logic ready
);
  logic [IC_W-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (refresh_evt && seen != IC_W'(INIT_CYC)) seen <= seen + 1'b1;
  end

  assign ready = (seen == IC_W'(INIT_CYC));

  // R9
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

// File: rtl/edram_seq.sv
module edram_seq
  import edram_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int COL_W = 4,
  parameter int AW = 6,
  parameter int SELF_REF_CYC = 20000,
  parameter int PAGE_MAX_CYC = 20000,
  localparam int WIN = (PAGE_MAX_CYC > SELF_REF_CYC) ? PAGE_MAX_CYC : SELF_REF_CYC,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [AW-1:0]    addr,
  input  logic             ready,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] acc_col,
  output logic             mem_wr,
  output logic             mem_rd,
  output logic             data_valid,
  output dram_kind_e       kind_q,
  output logic             kind_vld,
  output logic             refresh_evt,
  output logic             violation
);
  logic ras_q, cas_q, we_q;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  dram_phase_e phase, nxt_phase;
  dram_kind_e  cyc, evt;
  logic [COL_W-1:0] col_q;
  logic [CNT_W-1:0] cnt;
  logic any_cas, cas_held, last_read, viol_now;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n;
  assign cas_rise = ~cas_q & cas_n;
  assign we_fall  = we_q & ~we_n;
  assign acc_col  = cas_fall ? addr[COL_W-1:0] : col_q;

  always_comb begin
    nxt_phase = phase;
    evt = K_NONE;
    mem_wr = 1'b0;
    mem_rd = 1'b0;
    viol_now = 1'b0;
    case (phase)
      PH_IDLE: if (ras_fall) begin
        if (!cas_n) begin
          nxt_phase = PH_CBR;
          evt = K_CBR;
          if (cas_held && !last_read) viol_now = 1'b1;
        end else begin
          nxt_phase = PH_ACT;
        end
      end
      PH_ACT: begin
        if (ras_rise) begin
          nxt_phase = PH_IDLE;
          if (cyc != K_NONE) evt = cyc;
          else if (!any_cas) evt = K_RASONLY;
        end else begin
          if (cas_fall) begin
            if (!we_n) mem_wr = 1'b1;
            else mem_rd = 1'b1;
            if (!ready) viol_now = 1'b1;
          end else if (we_fall && !cas_n && cyc == K_READ) begin
            mem_wr = 1'b1;
            if (data_valid && !oe_n) viol_now = 1'b1;
          end
          if (cas_rise && cyc != K_NONE) evt = cyc;
          if (cnt == CNT_W'(PAGE_MAX_CYC - 1)) viol_now = 1'b1;
        end
      end
      PH_CBR: begin
        if (ras_rise) nxt_phase = PH_IDLE;
        else if (!cas_n && cnt == CNT_W'(SELF_REF_CYC - 1)) begin
          nxt_phase = PH_SELF;
          evt = K_SELF;
        end
      end
      default: if (ras_rise) nxt_phase = PH_IDLE;
    endcase
  end

  assign refresh_evt = (evt == K_CBR) || (evt == K_RASONLY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q <= 1'b1; cas_q <= 1'b1; we_q <= 1'b1;
      phase <= PH_IDLE;
      cyc <= K_NONE;
      row_q <= '0; col_q <= '0; cnt <= '0;
      any_cas <= 1'b0; cas_held <= 1'b0; last_read <= 1'b0;
      data_valid <= 1'b0;
      kind_q <= K_NONE; kind_vld <= 1'b0;
      violation <= 1'b0;
    end else begin
      ras_q <= ras_n; cas_q <= cas_n; we_q <= we_n;
      phase <= nxt_phase;
      kind_q <= evt;
      kind_vld <= (evt != K_NONE);
      violation <= violation | viol_now;

      if (phase == PH_IDLE && ras_fall) cnt <= '0;
      else if (phase == PH_ACT) begin
        if (cnt != CNT_W'(PAGE_MAX_CYC - 1)) cnt <= cnt + 1'b1;
      end else if (phase == PH_CBR) cnt <= cas_n ? '0 : cnt + 1'b1;

      if (phase == PH_IDLE && ras_fall && cas_n) begin
        row_q <= addr[ROW_W-1:0];
        any_cas <= 1'b0;
      end

      if (phase == PH_ACT && !ras_rise && cas_fall) begin
        col_q <= addr[COL_W-1:0];
        any_cas <= 1'b1;
        cyc <= we_n ? K_READ : K_EWR;
        last_read <= we_n;
      end else if (phase == PH_ACT && mem_wr) begin
        cyc <= K_LWR;
        last_read <= 1'b0;
      end else if (phase == PH_ACT && (cas_rise || ras_rise)) begin
        cyc <= K_NONE;
      end

      if (phase == PH_ACT && ras_rise && !cas_n) cas_held <= 1'b1;
      else if (cas_n) cas_held <= 1'b0;

      if (mem_rd) data_valid <= 1'b1;
      else if (mem_wr || we_fall || (ras_n && cas_n)) data_valid <= 1'b0;
    end
  end

  // R5
  both_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && cas_q) |-> !data_valid);

  // R3
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !data_valid);

  // R12
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation |=> violation);
endmodule

// File: rtl/edram_model.sv
module edram_model
  import edram_pkg::*;
#(
  parameter int ROW_W = 6,
  parameter int COL_W = 4,
  parameter int DQ_W = 4,
  parameter int INIT_CYC = 8,
  parameter int SELF_REF_CYC = 20000,
  parameter int PAGE_MAX_CYC = 20000,
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic            oe_n,
  input  logic [AW-1:0]   addr,
  input  logic [DQ_W-1:0] din,
  output logic [DQ_W-1:0] dq_out,
  output logic            dq_oe,
  output logic [2:0]      cyc_kind,
  output logic            cyc_kind_vld,
  output logic            ready,
  output logic            violation
);
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] acc_col;
  logic mem_wr, mem_rd, data_valid, refresh_evt;
  logic [DQ_W-1:0] rdata;
  dram_kind_e kind_q;

  edram_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .AW(AW),
    .SELF_REF_CYC(SELF_REF_CYC), .PAGE_MAX_CYC(PAGE_MAX_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .ready(ready), .row_q(row_q),
    .acc_col(acc_col), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .data_valid(data_valid), .kind_q(kind_q), .kind_vld(cyc_kind_vld),
    .refresh_evt(refresh_evt), .violation(violation)
  );

  edram_store #(.ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W)) u_store (
    .clk(clk), .wr(mem_wr), .idx({row_q, acc_col}), .wdata(din), .rdata(rdata)
  );

  edram_init #(.INIT_CYC(INIT_CYC)) u_init (
    .clk(clk), .rst_n(rst_n), .refresh_evt(refresh_evt), .ready(ready)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) dq_out <= '0;
    else if (mem_rd) dq_out <= rdata;
  end

  assign dq_oe = data_valid & ~oe_n;
  assign cyc_kind = kind_q;

  // R6
  refresh_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_kind_vld && cyc_kind == 3'd4) |-> !dq_oe);
endmodule

// File: tb/edram_model_test.sv
`timescale 1ns/1ps
module edram_model_test;
  localparam int SELF = 20000;
  localparam int PAGE = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [5:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dq_out;
  logic dq_oe, cyc_kind_vld, ready, violation;
  logic [2:0] cyc_kind;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [2:0] k; string r; } exp_t;
  exp_t exp_q[$];
  logic [3:0] model [1024];

  always #2.5 clk = ~clk;

  edram_model #(.SELF_REF_CYC(SELF), .PAGE_MAX_CYC(PAGE)) uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe),
    .cyc_kind(cyc_kind), .cyc_kind_vld(cyc_kind_vld), .ready(ready),
    .violation(violation)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_kind(logic [2:0] k, string r);
    exp_q.push_back('{k, r});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cyc_kind_vld) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected cycle report", {29'd0, cyc_kind}, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.r, {29'd0, cyc_kind}, {29'd0, e.k});
      end
    end
  end

  task automatic do_reset();
    chk("R2 pending reports before reset", exp_q.size(), 0);
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    tick(3);
    chk("R1 dq_oe in reset", dq_oe, 0);
    chk("R1 kind_vld in reset", cyc_kind_vld, 0);
    rst_n = 1'b1;
    tick(1);
    chk("R1 ready after reset", ready, 0);
    chk("R12 violation cleared by reset", violation, 0);
  endtask

  task automatic ras_only(logic [5:0] row);
    addr = row; ras_n = 1'b0; tick(3);
    chk("R6 no drive", dq_oe, 0);
    ras_n = 1'b1; expect_kind(3'd4, "R6 ras-only kind"); tick(3);
  endtask

  task automatic cbr(logic [5:0] a, int hold);
    addr = a; cas_n = 1'b0; tick(2);
    ras_n = 1'b0; expect_kind(3'd5, "R7 cbr kind"); tick(hold);
    ras_n = 1'b1; tick(1);
    cas_n = 1'b1; tick(3);
  endtask

  task automatic init_n(int n);
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 1) ras_only(6'(i));
      else cbr(6'(i + 10), 3);
    end
  endtask

  task automatic wr_early(logic [5:0] row, logic [3:0] col, logic [3:0] d);
    addr = row; ras_n = 1'b0; tick(1);
    addr = {2'b00, col}; din = d; we_n = 1'b0; oe_n = 1'b0; tick(1);
    cas_n = 1'b0; tick(1);
    chk("R3 early write never drives", dq_oe, 0);
    cas_n = 1'b1; expect_kind(3'd2, "R3 early write kind"); tick(1);
    chk("R3 early write off after cas", dq_oe, 0);
    we_n = 1'b1; oe_n = 1'b1; ras_n = 1'b1; tick(2);
    model[{row, col}] = d;
  endtask

  task automatic rd(logic [5:0] row, logic [3:0] col);
    addr = row; ras_n = 1'b0; tick(1);
    addr = {2'b00, col}; oe_n = 1'b0; cas_n = 1'b0; tick(1);
    chk("R2 read drives", dq_oe, 1);
    chk("R2 read data", dq_out, model[{row, col}]);
    cas_n = 1'b1; expect_kind(3'd1, "R2 read kind"); tick(1);
    chk("R5 held after cas rise", dq_oe, 1);
    chk("R5 data held after cas rise", dq_out, model[{row, col}]);
    ras_n = 1'b1; tick(1);
    chk("R5 off after both high", dq_oe, 0);
    oe_n = 1'b1; tick(1);
  endtask

  task automatic wr_late(logic [5:0] row, logic [3:0] col, logic [3:0] d, logic oe_lo);
    addr = row; ras_n = 1'b0; tick(1);
    addr = {2'b00, col}; oe_n = ~oe_lo; cas_n = 1'b0; tick(1);
    chk("R4 output state before we fall", dq_oe, oe_lo);
    addr = 6'h3f; we_n = 1'b0; din = d; tick(1);
    chk("R4 output off after we fall", dq_oe, 0);
    cas_n = 1'b1; we_n = 1'b1; expect_kind(3'd3, "R4 delayed write kind"); tick(1);
    ras_n = 1'b1; oe_n = 1'b1; tick(2);
    model[{row, col}] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    init_n(7);
    chk("R9 not ready after 7", ready, 0);
    init_n(1);
    chk("R9 ready after 8", ready, 1);
    chk("R9 no violation during init", violation, 0);

    wr_early(6'd5, 4'd3, 4'hA);
    wr_early(6'd63, 4'd15, 4'h5);
    wr_early(6'd0, 4'd0, 4'hF);
    wr_early(6'd5, 4'd4, 4'h6);
    rd(6'd5, 4'd3);
    rd(6'd63, 4'd15);
    rd(6'd0, 4'd0);

    // page mode with OE gating (R2, R5)
    addr = 6'd5; ras_n = 1'b0; tick(1);
    addr = 6'd3; oe_n = 1'b1; cas_n = 1'b0; tick(1);
    chk("R2 oe high keeps output off", dq_oe, 0);
    oe_n = 1'b0; tick(1);
    chk("R2 oe low drives", dq_oe, 1);
    cas_n = 1'b1; expect_kind(3'd1, "R2 page read kind"); tick(1);
    chk("R5 page data held", dq_out, 4'hA);
    addr = 6'd4; cas_n = 1'b0; tick(1);
    chk("R2 page second column", dq_out, 4'h6);
    cas_n = 1'b1; expect_kind(3'd1, "R2 page read kind"); tick(1);
    ras_n = 1'b1; tick(1);
    chk("R5 page off", dq_oe, 0);
    oe_n = 1'b1; tick(1);

    wr_late(6'd5, 4'd3, 4'h3, 1'b0);
    chk("R4 no violation with oe off", violation, 0);
    rd(6'd5, 4'd3);

    ras_only(6'd5);
    cbr(6'd5, 4);
    rd(6'd5, 4'd3);
    rd(6'd5, 4'd4);

    // legal hidden refresh after read (R11)
    addr = 6'd63; ras_n = 1'b0; tick(1);
    addr = 6'd15; oe_n = 1'b0; cas_n = 1'b0; tick(1);
    ras_n = 1'b1; expect_kind(3'd1, "R2 read before hidden"); tick(1);
    ras_n = 1'b0; expect_kind(3'd5, "R7 hidden refresh kind"); tick(2);
    chk("R11 hidden keeps drive", dq_oe, 1);
    chk("R11 hidden keeps data", dq_out, 4'h5);
    ras_n = 1'b1; tick(1);
    chk("R11 drive kept with cas low", dq_oe, 1);
    cas_n = 1'b1; tick(1);
    chk("R5 off after hidden", dq_oe, 0);
    oe_n = 1'b1; tick(1);
    chk("R11 legal hidden no violation", violation, 0);

    // short hold then self refresh (R8)
    cbr(6'd1, 200);
    cas_n = 1'b0; tick(2);
    ras_n = 1'b0;
    expect_kind(3'd5, "R7 cbr before self");
    expect_kind(3'd6, "R8 self refresh kind");
    tick(SELF + 5);
    ras_n = 1'b1; tick(1);
    cas_n = 1'b1; tick(2);
    chk("R8 self refresh no violation", violation, 0);

    // hidden refresh after write (R11)
    addr = 6'd7; ras_n = 1'b0; tick(1);
    addr = 6'd2; we_n = 1'b0; din = 4'h9; cas_n = 1'b0; tick(1);
    ras_n = 1'b1; expect_kind(3'd2, "R3 write before hidden"); tick(1);
    chk("R11 before bad hidden", violation, 0);
    ras_n = 1'b0; expect_kind(3'd5, "R7 bad hidden kind"); tick(1);
    chk("R11 hidden without read flags", violation, 1);
    ras_n = 1'b1; tick(1);
    cas_n = 1'b1; we_n = 1'b1; tick(5);
    chk("R12 violation held", violation, 1);

    // page held open too long (R10)
    do_reset();
    init_n(8);
    addr = 6'd3; ras_n = 1'b0; tick(PAGE - 10);
    chk("R10 below limit", violation, 0);
    tick(20);
    chk("R10 over limit", violation, 1);
    ras_n = 1'b1; expect_kind(3'd4, "R6 long pulse ras-only"); tick(3);
    chk("R12 sticky after page", violation, 1);

    // delayed write while output driven (R4)
    do_reset();
    init_n(8);
    wr_late(6'd9, 4'd9, 4'hC, 1'b1);
    chk("R4 driven at we fall flags", violation, 1);
    rd(6'd9, 4'd9);
    chk("R12 sticky after read", violation, 1);

    // access before init (R9)
    do_reset();
    wr_early(6'd1, 4'd1, 4'h2);
    chk("R9 access before init flags", violation, 1);
    chk("R9 still not ready", ready, 0);

    tick(3);
    chk("R2 all reports consumed", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule